// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Emulator

This block is a synthesizable slave that looks like a small serial EEPROM to a host on a three-wire bus: a serial clock, a chip select, a data input and a data output. The 128 x 16 storage is held in on-chip flops. The host frames each instruction with a start bit, an opcode and an address. It can read words back, program a single word, clear a single word, clear the whole array, or fill the whole array with one value. It can also set or clear the lock that guards all of these modifying commands.

Each modifying command that is accepted opens a busy window. Its length is a parameter counted in system clocks, which stands in for the millisecond-scale programming time of a real part. New instructions are ignored during the window. A host that raises chip select outside a read can poll readiness on the data output. The serial pins are sampled by the fast system clock through a parameterized synchronizer, and the block detects the serial clock edges internally.

Top module: `serial_eeprom_emu`

## Requirements
- R1: After reset every word holds 0xFFFF, the write lock is closed, and no busy window is active, so the data output reads 1 as soon as chip select is high.
- R2: A frame starts at the first data-in 1 sampled on a rising serial clock while chip select is high. Earlier 0 bits are skipped. Next come a 2-bit opcode (10 read, 01 write, 11 erase, 00 extended) and an 8-bit address, of which only bits 6:0 select a word. All fields are sent MSB first and sampled on rising serial clock edges.
- R3: A read drives a dummy 0 on the first falling serial clock edge after the address. The 16 data bits follow MSB first, one per falling edge. While chip select stays high the read runs on into the next address, and word 127 wraps to word 0.
- R4: A write (opcode 01) followed by 16 data bits stores that value in the addressed word when the lock is open.
- R5: Write, erase, erase-all and write-all change no word and start no busy window while the lock is closed.
- R6: Erase (opcode 11) sets the addressed word to 0xFFFF.
- R7: With the extended opcode, address bits 7:6 equal to 10 set every word to 0xFFFF. Address bits 7:6 equal to 01, followed by 16 data bits, store that value in every word.
- R8: Extended code 11 opens the lock and extended code 00 closes it. The lock stays open across completed busy windows.
- R9: Every accepted modifying command starts a busy window of BUSY_CLKS system clocks. A start bit sent during the window is ignored, and so is the frame that follows it.
- R10: With chip select high outside the data phase of a read, the data output is 0 during a busy window and 1 otherwise. With chip select low it is 0.
- R11: Dropping chip select in the middle of a frame aborts it with no change to any word, to the lock or to the busy state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins and runs the busy timer |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_sel | input | 1 | Chip select, active high |
| ser_di | input | 1 | Serial data from the host |
| ser_do | output | 1 | Serial read data, or ready status while selected and idle |

## Verification
The bench sends a write and an erase while the lock is closed. A guard that leaked would change the word read back, or would pull the status low. It sends a start bit early in a busy window. A design that still accepted frames there would apply the ignored erase. Sequential reads start at word 127, where a pointer that did not wrap, or a missing dummy bit, would show up as every word shifted by one bit. A write is cut off halfway by dropping chip select, where a design that committed partial data or started a busy window would be caught. Erase-all and write-all are confirmed at the first, middle and last word, and the bench also checks that the lock stays open after a completed cycle.

// File: rtl/serial_eeprom_pkg.sv
package serial_eeprom_pkg;

   typedef enum logic [1:0] {
      OP_EXT   = 2'b00,
      OP_WRITE = 2'b01,
      OP_READ  = 2'b10,
      OP_ERASE = 2'b11
   } op_e;

   typedef enum logic [1:0] {
      EXT_LOCK   = 2'b00,
      EXT_FILL   = 2'b01,
      EXT_WIPE   = 2'b10,
      EXT_UNLOCK = 2'b11
   } ext_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_DATA,
      ST_READ,
      ST_HOLD
   } fr_state_e;

endpackage

// File: rtl/sdev_edge.sv
module sdev_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ser_clk,
   input  logic ser_sel,
   input  logic ser_di,
   output logic sel_s,
   output logic di_s,
   output logic rise,
   output logic fall
);
   logic [2:0] raw, vis;
   logic       clk_prev;

   assign raw = {ser_clk, ser_sel, ser_di};

   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("SYNC_STAGES must not be negative");
   end

   if (SYNC_STAGES == 0) begin : g_direct
      assign vis = raw;
   end else begin : g_sync
      logic [2:0] pipe [SYNC_STAGES];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) pipe[i] <= '0;
         end else begin
            pipe[0] <= raw;
            for (int i = 1; i < SYNC_STAGES; i++) pipe[i] <= pipe[i-1];
         end
      end
      assign vis = pipe[SYNC_STAGES-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) clk_prev <= 1'b0;
      else        clk_prev <= vis[2];
   end

   assign sel_s = vis[1];
   assign di_s  = vis[0];
   assign rise  = vis[2] & ~clk_prev;
   assign fall  = ~vis[2] & clk_prev;
endmodule

// File: rtl/sdev_array.sv
module sdev_array #(
   parameter int ADDR_BITS = 7,
   parameter int DATA_BITS = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_BITS-1:0] wr_addr,
   input  logic [DATA_BITS-1:0] wr_data,
   input  logic                 fill_en,
   input  logic [DATA_BITS-1:0] fill_data,
   input  logic [ADDR_BITS-1:0] rd_addr,
   output logic [DATA_BITS-1:0] rd_data
);
   localparam int WORDS = 1 << ADDR_BITS;

   logic [DATA_BITS-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < WORDS; i++) mem[i] <= '1;
      end else if (fill_en) begin
         for (int i = 0; i < WORDS; i++) mem[i] <= fill_data;
      end else if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end

   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/sdev_timer.sv
module sdev_timer #(
   parameter int BUSY_CLKS = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int TW = $clog2(BUSY_CLKS + 1);

   logic [TW-1:0] cnt;

   if (BUSY_CLKS < 1) begin : g_bad_busy
      $error("BUSY_CLKS must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (start)      cnt <= TW'(BUSY_CLKS);
      else if (cnt != '0)  cnt <= cnt - TW'(1);
   end

   assign busy = (cnt != '0);
endmodule

// File: rtl/sdev_frame.sv
module sdev_frame
   import serial_eeprom_pkg::*;
#(
   parameter int ADDR_BITS  = 7,
   parameter int DATA_BITS  = 16,
   parameter int ADDR_FIELD = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sel_s,
   input  logic                 di_s,
   input  logic                 rise,
   input  logic                 fall,
   input  logic                 busy,
   input  logic [DATA_BITS-1:0] rd_data,
   output logic [ADDR_BITS-1:0] rd_ptr,
   output logic                 wr_en,
   output logic [ADDR_BITS-1:0] wr_addr,
   output logic [DATA_BITS-1:0] wr_data,
   output logic                 fill_en,
   output logic [DATA_BITS-1:0] fill_data,
   output logic                 start_busy,
   output logic                 wel,
   output logic                 reading,
   output logic                 dout
);
   localparam int HDR_BITS = 2 + ADDR_FIELD;
   localparam int MAXB     = (HDR_BITS > DATA_BITS) ? HDR_BITS : DATA_BITS;
   localparam int CW       = $clog2(MAXB + 1);
   localparam int IW       = $clog2(DATA_BITS);
   localparam logic [CW-1:0] HDR_LAST = CW'(HDR_BITS - 1);
   localparam logic [CW-1:0] DAT_LAST = CW'(DATA_BITS - 1);

   fr_state_e             state;
   logic [CW-1:0]         cnt;
   logic [HDR_BITS-1:0]   hdr, hdr_next, hv;
   logic [DATA_BITS-2:0]  dat;
   logic [DATA_BITS-1:0]  dat_next;
   logic [IW-1:0]         rd_idx;
   logic                  rd_dummy;
   logic                  hdr_done, dat_done;
   op_e                   op;
   ext_e                  ext;

   assign hdr_next = {hdr[HDR_BITS-2:0], di_s};
   assign dat_next = {dat, di_s};
   assign hv       = (state == ST_HDR) ? hdr_next : hdr;
   assign op       = op_e'(hv[HDR_BITS-1 -: 2]);
   assign ext      = ext_e'(hv[ADDR_FIELD-1 -: 2]);
   assign hdr_done = sel_s && rise && (state == ST_HDR)  && (cnt == HDR_LAST);
   assign dat_done = sel_s && rise && (state == ST_DATA) && (cnt == DAT_LAST);
   assign reading  = (state == ST_READ);
   assign wr_addr  = hv[ADDR_BITS-1:0];

   always_comb begin
      wr_en     = 1'b0;
      fill_en   = 1'b0;
      wr_data   = dat_next;
      fill_data = dat_next;
      if (hdr_done) begin
         if (op == OP_ERASE) begin
            wr_en   = wel;
            wr_data = '1;
         end else if (op == OP_EXT && ext == EXT_WIPE) begin
            fill_en   = wel;
            fill_data = '1;
         end
      end else if (dat_done) begin
         if (op == OP_WRITE)                    wr_en   = wel;
         else if (op == OP_EXT && ext == EXT_FILL) fill_en = wel;
      end
   end

   assign start_busy = wr_en | fill_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         hdr      <= '0;
         dat      <= '0;
         wel      <= 1'b0;
         rd_ptr   <= '0;
         rd_idx   <= '0;
         rd_dummy <= 1'b0;
         dout     <= 1'b0;
      end else if (!sel_s) begin
         state <= ST_IDLE;
         cnt   <= '0;
         dout  <= 1'b0;
      end else begin
         if (state != ST_READ) dout <= ~busy;
         case (state)
            ST_IDLE: if (rise && di_s && !busy) begin
               state <= ST_HDR;
               cnt   <= '0;
            end
            ST_HDR: if (rise) begin
               hdr <= hdr_next;
               cnt <= cnt + CW'(1);
               if (hdr_done) begin
                  cnt <= '0;
                  case (op)
                     OP_READ: begin
                        state    <= ST_READ;
                        rd_ptr   <= hdr_next[ADDR_BITS-1:0];
                        rd_dummy <= 1'b1;
                     end
                     OP_WRITE: state <= ST_DATA;
                     OP_ERASE: state <= ST_HOLD;
                     OP_EXT: begin
                        case (ext)
                           EXT_UNLOCK: begin wel <= 1'b1; state <= ST_HOLD; end
                           EXT_LOCK:   begin wel <= 1'b0; state <= ST_HOLD; end
                           EXT_WIPE:   state <= ST_HOLD;
                           EXT_FILL:   state <= ST_DATA;
                        endcase
                     end
                  endcase
               end
            end
            ST_DATA: if (rise) begin
               dat <= dat_next[DATA_BITS-2:0];
               cnt <= cnt + CW'(1);
               if (dat_done) state <= ST_HOLD;
            end
            ST_READ: if (fall) begin
               if (rd_dummy) begin
                  dout     <= 1'b0;
                  rd_dummy <= 1'b0;
                  rd_idx   <= IW'(DATA_BITS - 1);
               end else begin
                  dout <= rd_data[rd_idx];
                  if (rd_idx == '0) begin
                     rd_idx <= IW'(DATA_BITS - 1);
                     rd_ptr <= rd_ptr + ADDR_BITS'(1);
                  end else begin
                     rd_idx <= rd_idx - IW'(1);
                  end
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/serial_eeprom_emu.sv
module serial_eeprom_emu #(
   parameter int ADDR_BITS   = 7,
   parameter int DATA_BITS   = 16,
   parameter int ADDR_FIELD  = 8,
   parameter int BUSY_CLKS   = 1000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ser_clk,
   input  logic ser_sel,
   input  logic ser_di,
   output logic ser_do
);
   if (ADDR_FIELD < ADDR_BITS || ADDR_FIELD < 2) begin : g_bad_field
      $error("ADDR_FIELD must cover ADDR_BITS and be at least 2");
   end
   if (DATA_BITS < 2) begin : g_bad_data
      $error("DATA_BITS must be at least 2");
   end

   logic                 sel_s, di_s, rise, fall, busy;
   logic                 wr_en, fill_en, start_busy, wel, reading;
   logic [ADDR_BITS-1:0] rd_ptr, wr_addr;
   logic [DATA_BITS-1:0] rd_data, wr_data, fill_data;

   sdev_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_sel(ser_sel),
      .ser_di(ser_di), .sel_s(sel_s), .di_s(di_s), .rise(rise), .fall(fall)
   );

   sdev_timer #(.BUSY_CLKS(BUSY_CLKS)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(start_busy), .busy(busy)
   );

   sdev_array #(.ADDR_BITS(ADDR_BITS), .DATA_BITS(DATA_BITS)) u_array (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .fill_en(fill_en), .fill_data(fill_data),
      .rd_addr(rd_ptr), .rd_data(rd_data)
   );

   sdev_frame #(
      .ADDR_BITS(ADDR_BITS), .DATA_BITS(DATA_BITS), .ADDR_FIELD(ADDR_FIELD)
   ) u_frame (
      .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .di_s(di_s), .rise(rise),
      .fall(fall), .busy(busy), .rd_data(rd_data), .rd_ptr(rd_ptr),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .fill_en(fill_en), .fill_data(fill_data), .start_busy(start_busy),
      .wel(wel), .reading(reading), .dout(ser_do)
   );
endmodule

// File: rtl/sdev_checker.sv
module sdev_checker (
   input logic clk,
   input logic rst_n,
   input logic sel_s,
   input logic busy,
   input logic ser_do,
   input logic wr_en,
   input logic fill_en,
   input logic start_busy,
   input logic wel,
   input logic reading
);
   assert_quiet_deselect_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_s |=> !ser_do);

   assert_busy_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_s && busy && !reading) |=> !ser_do);

   assert_lock_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en || fill_en) |-> wel);

   assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !(wr_en || fill_en));

   assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      start_busy |=> busy);

   assert_one_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_en, fill_en}));
endmodule

bind serial_eeprom_emu sdev_checker u_chk (
   .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .busy(busy), .ser_do(ser_do),
   .wr_en(wr_en), .fill_en(fill_en), .start_busy(start_busy), .wel(wel),
   .reading(reading)
);

// File: tb/serial_eeprom_emu_tb.sv
module serial_eeprom_emu_tb;
   localparam int BUSY = 300;
   localparam int HALF = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_sel = 1'b0, ser_di = 1'b0;
   logic ser_do;

   int n_chk = 0, n_fail = 0;
   int cyc = 0;
   int t_cmd = -100000;
   int lowcnt = 0;
   bit done = 0;
   bit m_wel = 0;
   logic [15:0] model [128];

   always #2 clk = ~clk;

   serial_eeprom_emu #(.BUSY_CLKS(BUSY)) u_dut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_sel(ser_sel),
      .ser_di(ser_di), .ser_do(ser_do)
   );

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // R10: deselected output is 0, compared every clock once select settles
   always @(negedge clk) begin
      if (!ser_sel) lowcnt <= lowcnt + 1; else lowcnt <= 0;
      if (rst_n && lowcnt >= 4) chk(ser_do == 1'b0, "R10 deselect", ser_do, 0);
   end

   function automatic bit m_busy();
      return (cyc - t_cmd) < BUSY + 5;
   endfunction

   task automatic sbit(input logic b, output logic s);
      @(negedge clk); ser_clk = 1'b0; ser_di = b;
      repeat (HALF) @(negedge clk);
      s = ser_do;
      ser_clk = 1'b1;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic send(input logic b);
      logic s;
      sbit(b, s);
   endtask

   task automatic sel_up();
      @(negedge clk); ser_clk = 1'b0; ser_sel = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic sel_down();
      @(negedge clk); ser_clk = 1'b0; ser_sel = 1'b0; ser_di = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic hdr(input logic [1:0] op, input logic [7:0] a);
      send(1'b1); send(op[1]); send(op[0]);
      for (int i = 7; i >= 0; i--) send(a[i]);
   endtask

   task automatic word(input logic [15:0] d);
      for (int i = 15; i >= 0; i--) send(d[i]);
   endtask

   // modifying commands: model applies them when open and idle
   task automatic cmd_write(input logic [7:0] a, input logic [15:0] d);
      bit ok;
      sel_up(); ok = m_wel && !m_busy();
      hdr(2'b01, a); word(d);
      if (ok) begin model[a[6:0]] = d; t_cmd = cyc; end
      sel_down();
   endtask

   task automatic cmd_erase(input logic [7:0] a);
      bit ok;
      sel_up(); ok = m_wel && !m_busy();
      hdr(2'b11, a);
      if (ok) begin model[a[6:0]] = 16'hFFFF; t_cmd = cyc; end
      sel_down();
   endtask

   task automatic cmd_ext(input logic [1:0] code, input logic [15:0] d);
      bit ok;
      sel_up(); ok = !m_busy();
      hdr(2'b00, {code, 6'h15});
      if (code == 2'b01) word(d);
      if (ok) begin
         case (code)
            2'b11: m_wel = 1;
            2'b00: m_wel = 0;
            2'b10: if (m_wel) begin
               for (int i = 0; i < 128; i++) model[i] = 16'hFFFF;
               t_cmd = cyc;
            end
            default: if (m_wel) begin
               for (int i = 0; i < 128; i++) model[i] = d;
               t_cmd = cyc;
            end
         endcase
      end
      sel_down();
   endtask

   task automatic read_seq(input logic [7:0] a, input int n, input string req);
      logic s;
      logic [15:0] w;
      sel_up();
      hdr(2'b10, a);
      sbit(1'b0, s);
      chk(s == 1'b0, {req, " R3 dummy"}, s, 0);
      for (int k = 0; k < n; k++) begin
         w = '0;
         for (int i = 15; i >= 0; i--) begin sbit(1'b0, s); w[i] = s; end
         chk(w == model[(a[6:0] + k) % 128], req, w, model[(a[6:0] + k) % 128]);
      end
      sel_down();
   endtask

   task automatic status(input string req);
      int el;
      sel_up();
      el = cyc - t_cmd;
      if (el < BUSY - 40)      chk(ser_do == 1'b0, {req, " busy"}, ser_do, 0);
      else if (el > BUSY + 40) chk(ser_do == 1'b1, {req, " ready"}, ser_do, 1);
      sel_down();
   endtask

   task automatic wait_ready();
      repeat (BUSY + 60) @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 128; i++) model[i] = 16'hFFFF;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(ser_do == 1'b0, "R1 reset output", ser_do, 0);

      status("R1 idle after reset");
      read_seq(8'd0, 2, "R1 erased array");
      read_seq(8'd127, 2, "R3 wrap 127 to 0");

      // R5: lock closed
      cmd_write(8'd3, 16'h1234);
      status("R5 no busy when locked");
      cmd_erase(8'd9);
      status("R5 erase locked");
      read_seq(8'd3, 1, "R5 locked write ignored");

      // R8 + R4
      cmd_ext(2'b11, 16'h0);
      cmd_write(8'd3, 16'hA5C3);
      status("R9 busy after write");
      wait_ready();
      status("R9 ready after window");
      read_seq(8'd3, 1, "R4 write stored");

      // R2: address bit 7 ignored; R8: lock survives completed cycle
      cmd_write(8'h85, 16'h0F0F);
      wait_ready();
      read_seq(8'd5, 1, "R2 R8 high address bit");
      cmd_write(8'd4, 16'h8001);
      wait_ready();
      read_seq(8'd3, 3, "R3 sequential");

      // R2: leading zeros before start bit
      sel_up();
      send(1'b0); send(1'b0);
      hdr(2'b01, 8'd6); word(16'h6E6E);
      model[6] = 16'h6E6E; t_cmd = cyc;
      sel_down();
      wait_ready();
      read_seq(8'd6, 1, "R2 leading zeros");

      // R6
      cmd_erase(8'd3);
      wait_ready();
      read_seq(8'd3, 1, "R6 erase");

      // R9: erase issued inside busy window is dropped
      cmd_write(8'd10, 16'h1111);
      cmd_erase(8'd5);
      status("R9 still busy");
      wait_ready();
      read_seq(8'd5, 1, "R9 ignored during busy");
      read_seq(8'd10, 1, "R9 first write kept");

      // R11: abort mid-data
      sel_up();
      hdr(2'b01, 8'd20);
      for (int i = 0; i < 8; i++) send(1'b1);
      sel_down();
      status("R11 no busy after abort");
      read_seq(8'd20, 1, "R11 aborted write");

      // R7
      cmd_ext(2'b01, 16'h3C5A);
      wait_ready();
      read_seq(8'd0, 1, "R7 fill first");
      read_seq(8'd64, 1, "R7 fill middle");
      read_seq(8'd127, 1, "R7 fill last");
      cmd_ext(2'b10, 16'h0);
      status("R9 busy after wipe");
      wait_ready();
      read_seq(8'd64, 2, "R7 wipe");

      // R8: close lock
      cmd_ext(2'b00, 16'h0);
      cmd_write(8'd7, 16'h7777);
      status("R8 locked no busy");
      read_seq(8'd7, 1, "R8 lock closed");

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule